// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a 256-entry file of byte registers. The pins are oversampled by the system clock. The master drives SPI mode 0: SCLK idles low, MOSI is sampled on the rising edge and MISO changes on the falling edge. Every byte is 8 bits, and chip select stays low from the first header bit to the last data bit.

A transaction opens with three header bytes. The first is a command: bit 7 gives the direction and bits [6:0] give the data byte count minus one. The second is the low byte of a 16-bit register address and the third is the high byte. Data bytes follow and touch consecutive registers, one byte per register. For a write, the master sends the data on MOSI. For a read, the block returns the data on MISO.

A core-side read port gives the surrounding logic a view of the register contents. Raising chip select at any time abandons the transaction, and the next falling of chip select starts a fresh header.

Top module: `spi_reg_port`

## Requirements
- R1: After reset every register holds 0x00 and MISO is low.
- R2: A command byte with bit 7 = 1 is a write. The N data bytes that follow the two address bytes are stored at addresses A, A+1, ... A+N-1, where A is the second byte and N-1 is held in command bits [6:0].
- R3: Only the 8-bit low address byte selects a register, so the third header byte has no effect on where data lands.
- R4: The register address steps by one after each data byte and wraps from 0xFF to 0x00 inside a burst.
- R5: A command byte with bit 7 = 0 is a read. MISO presents register A most significant bit first, starting at the SCLK falling edge that follows the 24th rising edge, and then presents A+1 and onward, one byte per 8 SCLK cycles.
- R6: Data bytes sent after the programmed count have no effect. Write data past the count is not stored, and a read returns 0x00 past the count.
- R7: Raising chip select aborts the transaction. A partly received data byte is not stored, and the next transaction parses its header from the first byte.
- R8: MISO is low while chip select is high, during the three header bytes and throughout a write.
- R9: A command count field of 0x7F moves 128 data bytes in one burst, in both directions.
- R10: MOSI is taken on the rising SCLK edge, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; must be at least 8 times the SCLK rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock from the master, idles low |
| spi_cs_ni | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| core_raddr_i | input | 8 | Core-side register read address |
| core_rdata_o | output | 8 | Core-side register read data |

## Verification
The embedded assertions check these properties on every cycle: MISO stays low with chip select inactive, no register write happens without chip select, the remaining-count register stays within 1..128 during the data phase, the address advances by exactly one per data byte, and a chip-select release returns the parser to the command state. Other behaviours depend on whole byte sequences, and only the bench scenarios can show them. These are the placement of burst data, address wraparound, the exact falling edge where read data begins, the zeros past the programmed count, and the dropping of a partial byte on abort. The bench checks them by decoding MISO at the pins against a register model and by reading the core port.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W  = 8;
  localparam int LEN_W   = 7;
  localparam int DIR_BIT = 7;
  localparam int CNT_W   = LEN_W + 1;
  localparam int BIT_CW  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA,
    ST_DONE
  } hdr_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_active_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_pipe, cs_pipe, mosi_pipe;
  logic              sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_pipe <= '0;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
      sclk_q    <= 1'b0;
    end else begin
      sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_i};
      cs_pipe   <= {cs_pipe[STAGES-2:0], cs_ni};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_i};
      sclk_q    <= sclk_pipe[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_pipe[STAGES-1] & ~sclk_q;
  assign sclk_fall_o = ~sclk_pipe[STAGES-1] & sclk_q;
  assign cs_active_o = ~cs_pipe[STAGES-1];
  assign mosi_o      = mosi_pipe[STAGES-1];
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic              load_en_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              miso_o
);
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic [BIT_CW-1:0] bit_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr   <= '0;
      tx_sr   <= '0;
      bit_cnt <= '0;
    end else if (!cs_active_i) begin
      rx_sr   <= '0;
      tx_sr   <= '0;
      bit_cnt <= '0;
    end else begin
      if (sclk_rise_i) begin
        rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_i};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall_i) begin
        // count back at zero: previous byte finished, present the next one
        if (bit_cnt == '0) tx_sr <= load_en_i ? load_data_i : '0;
        else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign byte_done_o = cs_active_i & sclk_rise_i & (bit_cnt == BIT_CW'(BYTE_W - 1));
  assign rx_byte_o   = {rx_sr[BYTE_W-2:0], mosi_i};
  assign miso_o      = cs_active_i & tx_sr[BYTE_W-1];
endmodule

// File: rtl/spi_hdr_ctrl.sv
module spi_hdr_ctrl
  import spi_reg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              load_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << LEN_W);

  hdr_state_e       state;
  logic             is_write;
  logic [CNT_W-1:0] remain;
  logic [AW-1:0]    addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_CMD;
      is_write <= 1'b0;
      remain   <= '0;
      addr     <= '0;
    end else if (!cs_active_i) begin
      state <= ST_CMD;
    end else if (byte_done_i) begin
      unique case (state)
        ST_CMD: begin
          is_write <= rx_byte_i[DIR_BIT];
          remain   <= {1'b0, rx_byte_i[LEN_W-1:0]} + CNT_W'(1);
          state    <= ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          addr  <= rx_byte_i[AW-1:0];
          state <= ST_ADDR_HI;
        end
        ST_ADDR_HI: state <= ST_DATA;
        ST_DATA: begin
          addr   <= addr + 1'b1;
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = byte_done_i && (state == ST_DATA) && is_write;
  assign wr_addr_o = addr;
  assign wr_data_o = rx_byte_i;
  assign rd_addr_o = addr;
  assign load_en_o = (state == ST_DATA) && !is_write;

  a_r7_abort_to_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_active_i) |=> state == ST_CMD);
  a_r6_remain_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_DATA |-> remain != '0);
  a_r9_remain_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain <= CNT_MAX);
  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && state == ST_DATA) |=> addr == $past(addr) + AW'(1));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [BYTE_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [BYTE_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))   mem[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          spi_sclk_i,
  input  logic          spi_cs_ni,
  input  logic          spi_mosi_i,
  output logic          spi_miso_o,
  input  logic [AW-1:0] core_raddr_i,
  output logic [BYTE_W-1:0] core_rdata_o
);
  logic              sclk_rise, sclk_fall, cs_active, mosi_s;
  logic              byte_done, load_en, wr_en;
  logic [BYTE_W-1:0] rx_byte, wr_data, rd_data;
  logic [AW-1:0]     wr_addr, rd_addr;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .sclk_i(spi_sclk_i), .cs_ni(spi_cs_ni), .mosi_i(spi_mosi_i),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_active_o(cs_active), .mosi_o(mosi_s)
  );

  spi_bit_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_active_i(cs_active), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .mosi_i(mosi_s), .load_en_i(load_en), .load_data_i(rd_data),
    .byte_done_o(byte_done), .rx_byte_o(rx_byte), .miso_o(spi_miso_o)
  );

  spi_hdr_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_active_i(cs_active), .byte_done_i(byte_done), .rx_byte_i(rx_byte),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .load_en_o(load_en)
  );

  spi_regfile #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_a_i(rd_addr), .rdata_a_o(rd_data),
    .raddr_b_i(core_raddr_i), .rdata_b_o(core_rdata_o)
  );

  a_r8_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active |-> !spi_miso_o);
  a_r7_write_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> cs_active);
endmodule

// File: tb/spi_reg_port_bench.sv
module spi_reg_port_bench;
  localparam int HP = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] core_addr = '0;
  logic [7:0] core_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] model [256];
  logic [7:0] tx_buf [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         mon_read = 0;

  always #4 clk = ~clk;

  spi_reg_port u_spi_reg_port (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sclk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso),
    .core_raddr_i(core_addr), .core_rdata_o(core_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: decode MISO at the pins, compare against scoreboard
  int         mon_bits = 0;
  int         mon_idx = 0;
  logic [7:0] mon_sr = '0;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      mon_bits = 0;
      mon_idx  = 0;
    end else begin
      mon_sr = {mon_sr[6:0], miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (mon_read && mon_idx >= 3) begin
          if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", mon_sr, 0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(mon_sr == e, t, mon_sr, e);
          end
        end else begin
          check(mon_sr == 8'h00, "R8 miso idle byte", mon_sr, 0);
        end
        mon_idx++;
      end
    end
  end

  task automatic spi_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      repeat (HP) @(negedge clk);
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // write n bytes from tx_buf, send extra bytes after the count
  task automatic do_write(input logic [7:0] a, input logic [7:0] ahi, input int n, input int extra);
    mon_read = 0;
    cs_low();
    spi_bits({1'b1, 7'(n - 1)}, 8);
    spi_bits(a, 8);
    spi_bits(ahi, 8);
    for (int i = 0; i < n + extra; i++) begin
      spi_bits(tx_buf[i], 8);
      if (i < n) model[8'(a + i)] = tx_buf[i];
    end
    cs_high();
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input int extra, input string tg);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[8'(a + i)]);
      tag_q.push_back(tg);
    end
    for (int i = 0; i < extra; i++) begin
      exp_q.push_back(8'h00);
      tag_q.push_back("R6 read past count");
    end
    mon_read = 1;
    cs_low();
    spi_bits({1'b0, 7'(n - 1)}, 8);
    spi_bits(a, 8);
    spi_bits(8'h00, 8);
    for (int i = 0; i < n + extra; i++) spi_bits(8'h00, 8);
    cs_high();
    mon_read = 0;
  endtask

  task automatic core_check(input logic [7:0] a, input string tg);
    @(negedge clk);
    core_addr = a;
    @(negedge clk);
    check(core_data == model[a], tg, core_data, model[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    core_check(8'h00, "R1 reset reg 0x00");
    core_check(8'h10, "R1 reset reg 0x10");
    core_check(8'hFF, "R1 reset reg 0xFF");
    check(miso == 1'b0, "R1 miso after reset", miso, 0);

    // R2, R10: single write
    tx_buf[0] = 8'hA5;
    do_write(8'h10, 8'h00, 1, 0);
    core_check(8'h10, "R2 R10 single write");
    core_check(8'h11, "R2 neighbour untouched");

    // R3: high address byte ignored
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h82; tx_buf[2] = 8'h43; tx_buf[3] = 8'hC4;
    do_write(8'h20, 8'h7E, 4, 0);
    for (int i = 0; i < 4; i++) core_check(8'(8'h20 + i), "R3 burst with high byte 0x7E");

    // R4: wrap inside burst
    tx_buf[0] = 8'h5E; tx_buf[1] = 8'h5F; tx_buf[2] = 8'h60;
    do_write(8'hFE, 8'h00, 3, 0);
    core_check(8'hFE, "R4 wrap 0xFE");
    core_check(8'hFF, "R4 wrap 0xFF");
    core_check(8'h00, "R4 wrap 0x00");

    // R5 read with R6 bytes past count
    do_read(8'h20, 4, 2, "R5 burst read");
    do_read(8'hFF, 2, 0, "R4 R5 read across wrap");

    // R6: write past count ignored
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
    do_write(8'h40, 8'h00, 2, 2);
    core_check(8'h41, "R6 last counted byte");
    core_check(8'h42, "R6 extra byte not stored");
    core_check(8'h43, "R6 extra byte not stored");

    // R7: abort mid data byte
    mon_read = 0;
    cs_low();
    spi_bits(8'h80, 8); spi_bits(8'h50, 8); spi_bits(8'h00, 8);
    spi_bits(8'hFF, 4);
    cs_high();
    core_check(8'h50, "R7 partial byte dropped");
    // R7: abort after command byte, then fresh header
    cs_low();
    spi_bits(8'h80, 8);
    cs_high();
    tx_buf[0] = 8'h5A;
    do_write(8'h51, 8'h00, 1, 0);
    core_check(8'h51, "R7 fresh header after abort");
    core_check(8'h50, "R7 earlier target still clear");

    // R9: 128-byte burst both ways
    for (int i = 0; i < 128; i++) tx_buf[i] = 8'(i * 3 + 1);
    do_write(8'h80, 8'h00, 128, 0);
    core_check(8'h80, "R9 first of 128");
    core_check(8'hFF, "R9 last of 128");
    core_check(8'h00, "R9 past end untouched");
    do_read(8'h80, 128, 1, "R9 long read");

    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule